// File: doc/BRIEF.md
# External and Code Memory Address Generator

This block sits between a small 8-bit processor core and its off-core memory bus. For each access the core hands it an operation select, a direction flag, the accumulator, an 8-bit pointer register, a page byte, the 16-bit data pointer and the program counter. The block then forms one 16-bit bus address and runs a single request/acknowledge exchange with the memory side.

There are three ways to build the address. The first joins a page byte to an 8-bit pointer. The second uses the 16-bit data pointer as it is. The third adds the accumulator, as an unsigned offset, to a 16-bit base, which is either the data pointer or the address of the next instruction. The two external-data forms can read or write. The table forms reach code space and only read. The accumulator is the only source of written data and the only destination of read data. A read result is returned to the core through a one-cycle accumulator-update strobe.

The operation is accepted in the cycle after the core raises its valid signal. The request then stays up until the memory side acknowledges. While the block is busy, new requests are refused.

Top module: `xmem_addr_gen`

## Requirements
- R1: After reset, `bus_req`, `bus_rd`, `bus_wr`, `acc_we` and `busy` are all 0.
- R2: Operation 2'b00 drives `bus_addr = {page, ptr8}` with `bus_code` = 0.
- R3: Operation 2'b01 drives `bus_addr = dptr` with `bus_code` = 0.
- R4: Operation 2'b10 drives `bus_addr = (dptr + acc) mod 65536` with `bus_code` = 1 and `bus_rd` = 1.
- R5: Operation 2'b11 drives `bus_addr = (pc + acc) mod 65536` with `bus_code` = 1 and `bus_rd` = 1. Here `pc` is the address of the next instruction.
- R6: An operation 2'b1x presented with `wr` = 1 is refused. No bus request is raised, `busy` stays 0 and `acc_we` stays 0.
- R7: An operation 2'b0x with `wr` = 1 raises `bus_wr`. `bus_wdata` carries the accumulator value held at acceptance, even if `acc` changes later. No accumulator update follows the write.
- R8: `bus_req` rises in the cycle after `op_valid` is sampled while idle. It stays high until the first cycle with `bus_ack` = 1. During that time the address, space and strobes stay constant, and an `op_valid` arriving while `busy` is ignored.
- R9: For a read, `acc_we` is high for exactly the one cycle after the acknowledge. `acc_wdata` equals `bus_rdata` as sampled with the acknowledge.
- R10: `bus_rd` and `bus_wr` are never high together, and `bus_wr` is never high while `bus_code` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Core requests an access this cycle |
| op | input | 2 | 00 page:ptr8, 01 dptr, 10 code dptr+acc, 11 code pc+acc |
| wr | input | 1 | 1 = write, 0 = read |
| acc | input | 8 | Accumulator value (write data or offset) |
| ptr8 | input | 8 | Selected 8-bit pointer register |
| page | input | 8 | Upper address byte for the 8-bit pointer form |
| dptr | input | 16 | 16-bit data pointer |
| pc | input | 16 | Address of the next instruction |
| busy | output | 1 | An access is in progress |
| bus_req | output | 1 | Bus request |
| bus_ack | input | 1 | Bus acknowledge |
| bus_addr | output | 16 | Bus address |
| bus_code | output | 1 | 1 = code space, 0 = data space |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data returned by memory |
| acc_we | output | 1 | Accumulator update strobe |
| acc_wdata | output | 8 | Accumulator update value |

## Verification
The hardest case to reach is a change on the core-side inputs while a request is still waiting for its acknowledge. The bench holds `bus_ack` low for several cycles and, during that wait, raises `op_valid` again and changes the accumulator, pointer and operation. It then checks that the address, strobes and write data stay frozen and that no second request follows. The offset sums are driven with bases near 16'hFFFF so that the carry out of bit 15 must be dropped.

// File: rtl/xmem_addr_gen.sv
module xmem_addr_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [1:0]  op,
  input  logic        wr,
  input  logic [7:0]  acc,
  input  logic [7:0]  ptr8,
  input  logic [7:0]  page,
  input  logic [15:0] dptr,
  input  logic [15:0] pc,
  output logic        busy,
  output logic        bus_req,
  input  logic        bus_ack,
  output logic [15:0] bus_addr,
  output logic        bus_code,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  output logic        acc_we,
  output logic [7:0]  acc_wdata
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DONE} state_t;

  state_t      state;
  logic [15:0] addr_q;
  logic        code_q;
  logic        wr_q;
  logic [7:0]  wdata_q;
  logic        acc_we_q;
  logic [7:0]  acc_q;
  logic [15:0] next_addr;
  logic        is_code;
  logic        accept;

  assign is_code = op[1];
  assign accept  = op_valid && !(is_code && wr);

  always_comb begin
    case (op)
      2'b00:   next_addr = {page, ptr8};
      2'b01:   next_addr = dptr;
      2'b10:   next_addr = dptr + {8'h00, acc};
      default: next_addr = pc + {8'h00, acc};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      code_q   <= 1'b0;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
      acc_we_q <= 1'b0;
      acc_q    <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          acc_we_q <= 1'b0;
          if (accept) begin
            state   <= S_REQ;
            addr_q  <= next_addr;
            code_q  <= is_code;
            wr_q    <= wr && !is_code;
            wdata_q <= acc;
          end
        end
        S_REQ: begin
          if (bus_ack) begin
            state    <= S_DONE;
            acc_we_q <= !wr_q;
            if (!wr_q) acc_q <= bus_rdata;
          end
        end
        default: begin
          state    <= S_IDLE;
          acc_we_q <= 1'b0;
        end
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign bus_req   = (state == S_REQ);
  assign bus_addr  = addr_q;
  assign bus_code  = code_q;
  assign bus_rd    = bus_req && !wr_q;
  assign bus_wr    = bus_req && wr_q;
  assign bus_wdata = wdata_q;
  assign acc_we    = acc_we_q;
  assign acc_wdata = acc_q;

  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr) && !(bus_code && bus_wr));

  a_r6_code_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op[1] && wr) |=> !busy);

  a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_code)
                               && $stable(bus_wr) && $stable(bus_wdata)));

  a_r9_update_after_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_ack) |=> (acc_we && acc_wdata == $past(bus_rdata)));

  a_r9_update_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |=> !acc_we);

  a_r7_no_update_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_ack) |=> !acc_we);

endmodule

// File: tb/tb_xmem_addr_gen.sv
module tb_xmem_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        wr = 1'b0;
  logic [7:0]  acc = '0, ptr8 = '0, page = '0, bus_rdata = '0;
  logic [15:0] dptr = '0, pc = '0;
  logic        bus_ack = 1'b0;
  logic        busy, bus_req, bus_code, bus_rd, bus_wr, acc_we;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, acc_wdata;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  xmem_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .wr(wr),
    .acc(acc), .ptr8(ptr8), .page(page), .dptr(dptr), .pc(pc),
    .busy(busy), .bus_req(bus_req), .bus_ack(bus_ack), .bus_addr(bus_addr),
    .bus_code(bus_code), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .acc_we(acc_we), .acc_wdata(acc_wdata)
  );

  // {op, wr, acc, ptr8, page, dptr, pc, rdata, expected addr, expected code}
  localparam logic [83:0] VEC [8] = '{
    {2'b00, 1'b0, 8'h11, 8'h34, 8'h12, 16'h0000, 16'h0000, 8'hA5, 16'h1234, 1'b0},
    {2'b00, 1'b1, 8'h5A, 8'hFF, 8'h00, 16'h0000, 16'h0000, 8'h00, 16'h00FF, 1'b0},
    {2'b01, 1'b0, 8'h77, 8'h00, 8'h00, 16'hBEEF, 16'h0000, 8'h3C, 16'hBEEF, 1'b0},
    {2'b01, 1'b1, 8'hC3, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'h00, 16'h0000, 1'b0},
    {2'b10, 1'b0, 8'hFF, 8'h00, 8'h00, 16'h1000, 16'h0000, 8'h81, 16'h10FF, 1'b1},
    {2'b10, 1'b0, 8'h20, 8'h00, 8'h00, 16'hFFF0, 16'h0000, 8'h42, 16'h0010, 1'b1},
    {2'b11, 1'b0, 8'h80, 8'h00, 8'h00, 16'h0000, 16'h2345, 8'h9E, 16'h23C5, 1'b1},
    {2'b11, 1'b0, 8'h01, 8'h00, 8'h00, 16'h0000, 16'hFFFF, 8'h07, 16'h0000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string addr_tag(input logic [1:0] o);
    case (o)
      2'b00:   return "R2 address";
      2'b01:   return "R3 address";
      2'b10:   return "R4 address";
      default: return "R5 address";
    endcase
  endfunction

  task automatic run_vec(input logic [83:0] v, input int wait_cycles);
    logic [7:0] a;
    logic       w;
    a = v[80:73];
    w = v[81];
    @(negedge clk);
    op = v[83:82]; wr = w; acc = a; ptr8 = v[72:65]; page = v[64:57];
    dptr = v[56:41]; pc = v[40:25]; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R8 request raised", 32'(bus_req), 32'd1);
    chk(addr_tag(v[83:82]), 32'(bus_addr), 32'(v[16:1]));
    chk("R2/R3 R4/R5 space select", 32'(bus_code), 32'(v[0]));
    chk("R7 R9 strobe direction", 32'({bus_rd, bus_wr}), w ? 32'd1 : 32'd2);
    if (w) chk("R7 write data", 32'(bus_wdata), 32'(a));
    for (int k = 0; k < wait_cycles; k++) begin
      acc = ~a;
      @(negedge clk);
      chk("R8 held while waiting", 32'({bus_req, bus_addr}), 32'({1'b1, v[16:1]}));
      if (w) chk("R7 write data held", 32'(bus_wdata), 32'(a));
    end
    bus_ack = 1'b1; bus_rdata = v[24:17];
    @(negedge clk);
    bus_ack = 1'b0; bus_rdata = 8'hEE;
    chk("R8 request dropped after ack", 32'(bus_req), 32'd0);
    chk("R9 R7 update strobe", 32'(acc_we), w ? 32'd0 : 32'd1);
    if (!w) chk("R9 update value", 32'(acc_wdata), 32'(v[24:17]));
    @(negedge clk);
    chk("R9 update one cycle", 32'({acc_we, busy}), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", 32'({bus_req, bus_rd, bus_wr, acc_we, busy}), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) run_vec(VEC[i], i % 3);

    // R6: code-space writes refused, both code forms
    for (int o = 2; o < 4; o++) begin
      @(negedge clk);
      op = 2'(o); wr = 1'b1; acc = 8'h10; dptr = 16'h4000; pc = 16'h5000; op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      chk("R6 code write refused", 32'({bus_req, busy, bus_wr}), 32'd0);
      @(negedge clk);
      chk("R6 no update after refused write", 32'({acc_we, busy}), 32'd0);
    end

    // R8: new op_valid while busy is ignored
    @(negedge clk);
    op = 2'b01; wr = 1'b0; dptr = 16'hA0A0; op_valid = 1'b1;
    @(negedge clk);
    op = 2'b00; page = 8'h55; ptr8 = 8'h66; wr = 1'b1; acc = 8'h99;
    @(negedge clk);
    chk("R8 address frozen while busy", 32'(bus_addr), 32'h0000A0A0);
    chk("R8 direction frozen while busy", 32'({bus_rd, bus_wr}), 32'd2);
    bus_ack = 1'b1; bus_rdata = 8'h6D;
    @(negedge clk);
    op_valid = 1'b0; bus_ack = 1'b0;
    chk("R9 update after frozen read", 32'({acc_we, acc_wdata}), 32'h16D);
    @(negedge clk);
    chk("R8 no second request", 32'({bus_req, busy, acc_we}), 32'd0);
    @(negedge clk);
    chk("R8 still idle", 32'(bus_req), 32'd0);

    // R1: reset in the middle of a request
    op = 2'b01; wr = 1'b1; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears request", 32'({bus_req, bus_rd, bus_wr, acc_we, busy}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R8 actual=hung expected=complete");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule